// File: doc/BRIEF.md
# NAND Block Hamming Parity Engine

This engine builds a 24-bit Hamming-style check code over one 512-byte NAND data block while that block streams across an 8-bit or 16-bit data path. Software starts a block with a clear pulse, selects the bus width, and raises enable. Each accepted data strobe then folds one byte into the running parity. In wide mode it folds two bytes. When the 512th byte has been taken, the engine raises a done flag. After that it freezes until the next clear. The same start sequence serves both page reads and page writes.

The result has two 12-bit groups. One group gathers the "index bit is 0" halves of every parity pair. The other gathers the "index bit is 1" halves. Each pair comes either from a bit position inside a byte (column) or from the byte's position in the block (line). Software packs the three code bytes from the result: low byte from bits 7:0, middle byte from bits 23:16, and top byte as bits 27:24 over bits 11:8.

Top module: `nand_ecc_accum`

## Requirements
- R1: A clear pulse zeroes the result, the byte count and the done flag on the next clock edge. A strobe in the same cycle as clear is dropped.
- R2: The result places the even-half group in bits 11:0 and the odd-half group in bits 27:16. Bits 15:12 and 31:28 are zero. Inside each group, bits 2:0 hold column pairs k=0..2 and bits 11:3 hold line pairs k=0..8.
- R3: Column pair k: each set data bit j toggles the even half when bit k of j is 0, and toggles the odd half when it is 1.
- R4: Line pair k: each set data bit of the byte at block index i toggles the even half when bit k of i is 0, and toggles the odd half when it is 1. Byte indices run from 0 to 511.
- R5: With the width select low, each strobe adds the byte on data bits 7:0. Data bits 15:8 have no effect.
- R6: With the width select high, each strobe adds two bytes: bits 7:0 at index n and bits 15:8 at index n+1.
- R7: After 512 bytes the done flag rises. Later strobes leave the result unchanged until a clear.
- R8: While enable is low, strobes leave the result and the byte count unchanged.
- R9: A block of all 0xFF bytes yields a zero result with done set.
- R10: The result reflects a strobe on the first clock edge after it. With no strobe, it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear pulse: zero parity, count and done |
| en_i | input | 1 | Accumulate enable |
| wide_i | input | 1 | 1 = 16-bit strobes (two bytes), 0 = 8-bit |
| stb_i | input | 1 | Data strobe |
| data_i | input | 16 | Data word; low byte first |
| result_o | output | 32 | Parity result, two 12-bit groups |
| done_o | output | 1 | Block complete |

## Verification
The situations hardest to reach from the ports are the block boundary and the case where the index is high in the line parity. The bench therefore streams complete blocks in both widths, so every byte index up to 511 and every line bit in both halves is exercised. It then keeps strobing past done. Two hand-computed one-byte steps pin the exact bit layout. A pause with enable low in the middle of a wide block checks that the count resumes at the right index. A strobe issued together with clear checks the clear priority.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int ECC_BLOCK_BYTES = 512;
    localparam int ECC_IDX_W       = $clog2(ECC_BLOCK_BYTES);
    localparam int ECC_LANE_W      = 8;
    localparam int ECC_COL_PAIRS   = $clog2(ECC_LANE_W);
    localparam int ECC_GRP_W       = ECC_COL_PAIRS + ECC_IDX_W;
    localparam int ECC_RES_W       = 32;
    localparam int ECC_ODD_LSB     = 16;

    typedef struct packed {
        logic [ECC_GRP_W-1:0] odd;
        logic [ECC_GRP_W-1:0] even;
    } ecc_pair_t;

    // Selects the bit positions of a byte whose position bit k equals half.
    function automatic logic [ECC_LANE_W-1:0] col_mask(input int k, input logic half);
        logic [ECC_LANE_W-1:0] m;
        for (int j = 0; j < ECC_LANE_W; j++) begin
            m[j] = (((j >> k) & 1) == 1) == half;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_lane_term.sv
module ecc_lane_term
    import nand_ecc_pkg::*;
(
    input  logic [ECC_LANE_W-1:0] byte_i,
    input  logic [ECC_IDX_W-1:0]  idx_i,
    input  logic                  live_i,
    output ecc_pair_t             term_o
);
    logic byte_par;

    always_comb begin
        byte_par = ^byte_i;
        term_o   = '0;
        for (int k = 0; k < ECC_COL_PAIRS; k++) begin
            term_o.even[k] = ^(byte_i & col_mask(k, 1'b0));
            term_o.odd[k]  = ^(byte_i & col_mask(k, 1'b1));
        end
        for (int k = 0; k < ECC_IDX_W; k++) begin
            term_o.even[ECC_COL_PAIRS+k] = byte_par & ~idx_i[k];
            term_o.odd[ECC_COL_PAIRS+k]  = byte_par &  idx_i[k];
        end
        if (!live_i) begin
            term_o = '0;
        end
    end
endmodule

// File: rtl/ecc_byte_counter.sv
module ecc_byte_counter
    import nand_ecc_pkg::*;
#(
    parameter int BLOCK_BYTES = ECC_BLOCK_BYTES,
    parameter int IDX_W       = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             step2,
    output logic [IDX_W-1:0] count_o,
    output logic             done_o
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(BLOCK_BYTES);

    logic [IDX_W:0] cnt;
    logic [IDX_W:0] nxt;

    always_comb begin
        nxt = cnt + (step2 ? (IDX_W+1)'(2) : (IDX_W+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (adv && !done_o) begin
            cnt <= (nxt >= LIMIT) ? LIMIT : nxt;
            if (nxt >= LIMIT) begin
                done_o <= 1'b1;
            end
        end
    end

    assign count_o = cnt[IDX_W-1:0];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr) |=> done_o); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> cnt == LIMIT); // R7
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         en_i,
    input  logic                         wide_i,
    input  logic                         stb_i,
    input  logic [LANES*ECC_LANE_W-1:0]  data_i,
    output logic [ECC_RES_W-1:0]         result_o,
    output logic                         done_o
);
    localparam int GAP_LO = ECC_ODD_LSB - ECC_GRP_W;
    localparam int GAP_HI = ECC_RES_W - ECC_ODD_LSB - ECC_GRP_W;

    logic [ECC_IDX_W-1:0] count;
    logic                 accept;
    ecc_pair_t            acc;
    ecc_pair_t            lane_term [LANES];
    ecc_pair_t            step_term;

    assign accept = stb_i && en_i && !done_o && !clr_i;

    ecc_byte_counter #(
        .BLOCK_BYTES (ECC_BLOCK_BYTES),
        .IDX_W       (ECC_IDX_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_i),
        .adv     (accept),
        .step2   (wide_i),
        .count_o (count),
        .done_o  (done_o)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ecc_lane_term u_term (
            .byte_i (data_i[l*ECC_LANE_W +: ECC_LANE_W]),
            .idx_i  (count + ECC_IDX_W'(l)),
            .live_i ((l == 0) || wide_i),
            .term_o (lane_term[l])
        );
    end

    always_comb begin
        step_term = '0;
        for (int l = 0; l < LANES; l++) begin
            step_term = step_term ^ lane_term[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc <= '0;
        end else if (accept) begin
            acc <= acc ^ step_term;
        end
    end

    assign result_o = {{GAP_HI{1'b0}}, acc.odd, {GAP_LO{1'b0}}, acc.even};

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (result_o == '0) && !done_o); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(result_o)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr_i) |=> $stable(result_o)); // R7
    AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!stb_i && !clr_i) |=> $stable(result_o)); // R10
endmodule

// File: tb/test_nand_ecc_accum.sv
module test_nand_ecc_accum;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        wide = 1'b0;
    logic        stb = 1'b0;
    logic [15:0] data = '0;
    logic [31:0] result;
    logic        done;

    always #2.5 clk = ~clk;

    nand_ecc_accum i_nand_ecc_accum (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .en_i     (en),
        .wide_i   (wide),
        .stb_i    (stb),
        .data_i   (data),
        .result_o (result),
        .done_o   (done)
    );

    typedef struct {
        logic [31:0] r;
        logic        d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;

    // reference model state
    logic [11:0] m_even = '0;
    logic [11:0] m_odd = '0;
    int          m_cnt = 0;
    logic        m_done = 1'b0;

    function automatic logic [31:0] m_pack();
        return {4'b0, m_odd, 4'b0, m_even};
    endfunction

    // bit-by-bit parity definition from R3/R4
    task automatic m_byte(input int idx, input logic [7:0] d);
        for (int j = 0; j < 8; j++) begin
            if (d[j]) begin
                for (int k = 0; k < 3; k++) begin
                    if ((j >> k) & 1) m_odd[k] = ~m_odd[k];
                    else              m_even[k] = ~m_even[k];
                end
                for (int k = 0; k < 9; k++) begin
                    if ((idx >> k) & 1) m_odd[3+k] = ~m_odd[3+k];
                    else                m_even[3+k] = ~m_even[3+k];
                end
            end
        end
    endtask

    task automatic push(input logic [31:0] r, input logic d, input string tag);
        exp_t e;
        e.r = r; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    // one cycle of stimulus; model update; expectation pushed
    task automatic step(input logic c, input logic s, input logic [15:0] d, input string tag);
        clr = c; stb = s; data = d;
        @(posedge clk); #1;
        clr = 1'b0; stb = 1'b0;
        if (c) begin
            m_even = '0; m_odd = '0; m_cnt = 0; m_done = 1'b0;
        end else if (s && en && !m_done) begin
            m_byte(m_cnt, d[7:0]);
            if (wide) m_byte(m_cnt + 1, d[15:8]);
            m_cnt = m_cnt + (wide ? 2 : 1);
            if (m_cnt >= 512) m_done = 1'b1;
        end
        push(m_pack(), m_done, tag);
    endtask

    // monitor: compares each expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (result !== e.r || done !== e.d) begin
                    bad++;
                    $display("FAIL %s: result=%08h done=%0b expected result=%08h done=%0b",
                             e.tag, result, done, e.r, e.d);
                end
            end
        end
    end

    // direct literal check, independent of the model
    task automatic lit(input logic [31:0] r, input logic d, input string tag);
        @(negedge clk);
        total++;
        if (result !== r || done !== d) begin
            bad++;
            $display("FAIL %s: result=%08h done=%0b expected result=%08h done=%0b",
                     tag, result, done, r, d);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        int wd = 0;
        while (wd < 200000) begin
            @(posedge clk);
            wd++;
        end
        total++;
        bad++;
        $display("FAIL watchdog: cycles=%0d expected below=%0d", wd, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        lit(32'h0, 1'b0, "R1 reset state");

        // R2 R3 R4 hand-computed layout
        en = 1'b1; wide = 1'b0;
        step(1'b1, 1'b0, 16'h0, "R1 clear");
        step(1'b0, 1'b1, 16'h0001, "R3 byte0=01");
        lit(32'h0000_0FFF, 1'b0, "R2 R3 R4 byte0=01 layout");
        step(1'b0, 1'b1, 16'h0080, "R4 byte1=80");
        lit(32'h000F_000F, 1'b0, "R2 R3 R4 byte1=80 layout");

        // R5 full 8-bit block with noise in the upper byte
        step(1'b1, 1'b0, 16'h0, "R1 clear");
        for (int i = 0; i < 512; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            step(1'b0, 1'b1, w, "R5 R10 8-bit stream");
        end
        // R7 strobes after done ignored
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'h5A3C, "R7 after done");

        // R1 clear wins over simultaneous strobe
        step(1'b1, 1'b1, 16'h00FF, "R1 clear with strobe");

        // R6 16-bit block with R8 enable pause mid-way
        wide = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (i == 100) begin
                en = 1'b0;
                for (int p = 0; p < 5; p++) step(1'b0, 1'b1, 16'hA55A, "R8 disabled strobe");
                en = 1'b1;
            end
            step(1'b0, 1'b1, 16'($urandom), "R6 16-bit stream");
        end
        step(1'b0, 1'b0, 16'h0, "R10 idle hold");

        // R9 erased block, both widths
        step(1'b1, 1'b0, 16'h0, "R1 clear");
        for (int i = 0; i < 256; i++) step(1'b0, 1'b1, 16'hFFFF, "R9 erased wide");
        lit(32'h0, 1'b1, "R9 erased wide result");
        wide = 1'b0;
        step(1'b1, 1'b0, 16'h0, "R1 clear");
        for (int i = 0; i < 512; i++) step(1'b0, 1'b1, 16'h00FF, "R9 erased narrow");
        lit(32'h0, 1'b1, "R9 erased narrow result");

        // R6 lane order: single wide strobe 0x8001 at index 0,1
        wide = 1'b1;
        step(1'b1, 1'b0, 16'h0, "R1 clear");
        step(1'b0, 1'b1, 16'h8001, "R6 lane order");
        lit(32'h000F_000F, 1'b0, "R6 low byte index0 high index1");
        held = result;

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule